// File: doc/BRIEF.md
# Segment-Table Address Translator

This block turns a virtual address into a physical address through a two-level lookup held in memory. The segment number in the top bits of the address selects one descriptor in a fixed segment table. That descriptor says whether the segment's page table is in memory, where the table starts, and how many entries in it are valid. The page index in the middle bits then selects one entry from that page table. The entry gives the frame number, and the frame number joined to the page offset forms the physical address.

Each translation makes one descriptor read. It makes a second read, for the page entry, only when the descriptor allows it. The result is one of four outcomes: success, a non-resident page table, a page index beyond the table's length, or an absent page. Software uses these outcomes to decide what to build or fetch before it retries the translation.

Requests enter on a valid/ready pair. `req_ready` is high only while the block is idle, so a request held by the source simply waits; the virtual address must stay stable until it is taken. Memory reads leave on a second valid/ready pair. The address is held until the memory accepts it, and at most one read is outstanding. The read response has no back-pressure. The result is a single-cycle `done` pulse with no back-pressure.

Top module: `seg_xlate`

## Requirements
- R1: `req_ready` is high only in the idle state. A request is taken on a cycle where `req_valid` and `req_ready` are both high. From that cycle through the `done` cycle, `req_ready` stays low, so a request held during the `done` cycle is taken only on a later cycle.
- R2: The first memory read of each translation is at `SEG_BASE + 4*seg`, where seg is `va[31:24]`.
- R3: A descriptor word has these fields: bit 31 is the resident flag, bits 30:8 are the page-table base in 512-byte units, and bits 7:0 are the entry count.
- R4: If the descriptor's resident flag is 0, the fault is 01 and no page-entry read is made. This check takes priority over the length check.
- R5: If the page index `va[23:12]` is greater than or equal to min(count, 128), the fault is 11 and no page-entry read is made. A count above 128 behaves as 128, and a count of 0 rejects every index.
- R6: The page-entry read is at `(base << 9) + 4*index`.
- R7: A page entry with bit 31 equal to 0 gives fault 10.
- R8: A page entry with bit 31 equal to 1 gives fault 00 and `paddr = {entry[19:0], va[11:0]}`, after exactly two memory reads.
- R9: `done` is high for exactly one cycle per translation. `fault` and `paddr` are valid in that cycle, and `paddr` is 0 whenever `fault` is not 00.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the request and its address stay unchanged on the next cycle. No new read is issued before the previous read's response.
- R11: During reset the block is idle: `req_ready` is 1, and `done` and `mem_req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_va | input | 32 | Virtual address to translate |
| done | output | 1 | One-cycle result strobe |
| fault | output | 2 | 00 ok, 01 non-resident table, 10 absent page, 11 length violation |
| paddr | output | 32 | Physical address, valid with `done` |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Read data word |

## Verification
Two cases can fall in the same cycle. First, the residency test and the length test are both decided on the descriptor in the cycle its response arrives. The bench therefore builds descriptors that are both non-resident and too short for the requested index, and expects fault 01 with a single read. Second, the result strobe and a pending request can coincide. The bench keeps `req_valid` asserted with the next address all through a translation, including the `done` cycle. It then compares `req_ready`, every memory address and the read count on every clock against its own model, which accepts a request only on the cycle after the strobe.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    FLT_NONE = 2'b00,
    FLT_SEG  = 2'b01,
    FLT_PAGE = 2'b10,
    FLT_LEN  = 2'b11
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DREQ,
    ST_DWAIT,
    ST_PREQ,
    ST_PWAIT,
    ST_DONE
  } state_e;

endpackage

// File: rtl/seg_xlate_addr.sv
module seg_xlate_addr #(
  parameter int unsigned    VA_W        = 32,
  parameter int unsigned    SEG_W       = 8,
  parameter int unsigned    OFF_W       = 12,
  parameter int unsigned    PA_W        = 32,
  parameter int unsigned    BASE_W      = 23,
  parameter int unsigned    ENTRY_BYTES = 4,
  parameter int unsigned    DESC_BYTES  = 4,
  parameter int unsigned    TBL_SHIFT   = 9,
  parameter logic [PA_W-1:0] SEG_BASE   = 32'hF000_0000
) (
  input  logic [VA_W-OFF_W-1:0] va_hi,
  input  logic [BASE_W-1:0]     tbl_base,
  output logic [PA_W-1:0]       desc_addr,
  output logic [PA_W-1:0]       pte_addr
);
  localparam int unsigned IDX_W    = VA_W - SEG_W - OFF_W;
  localparam int unsigned ENTRY_SH = $clog2(ENTRY_BYTES);
  localparam int unsigned DESC_SH  = $clog2(DESC_BYTES);

  logic [SEG_W-1:0] seg;
  logic [IDX_W-1:0] idx;

  assign seg = va_hi[IDX_W +: SEG_W];
  assign idx = va_hi[IDX_W-1:0];

  // descriptor slot inside the fixed segment table
  assign desc_addr = SEG_BASE + (PA_W'(seg) << DESC_SH);
  // entry slot: table start plus scaled page index
  assign pte_addr  = (PA_W'(tbl_base) << TBL_SHIFT) + (PA_W'(idx) << ENTRY_SH);

endmodule

// File: rtl/seg_xlate_classify.sv
module seg_xlate_classify
  import seg_xlate_pkg::*;
#(
  parameter int unsigned IDX_W       = 12,
  parameter int unsigned LEN_W       = 8,
  parameter int unsigned MAX_ENTRIES = 128
) (
  input  logic             resident,
  input  logic [LEN_W-1:0] count,
  input  logic [IDX_W-1:0] idx,
  input  logic             present,
  output fault_e           desc_flt,
  output fault_e           pte_flt
);
  localparam int unsigned LIM_W = $clog2(MAX_ENTRIES + 1);
  localparam int unsigned CMP_W = ((IDX_W > LIM_W) ? IDX_W : LIM_W) + 1;

  logic [LIM_W-1:0] limit;
  logic             too_long;

  generate
    if (((1 << LEN_W) - 1) > MAX_ENTRIES) begin : g_clamp
      assign limit = (CMP_W'(count) > CMP_W'(MAX_ENTRIES)) ? LIM_W'(MAX_ENTRIES)
                                                           : LIM_W'(count);
    end else begin : g_pass
      assign limit = LIM_W'(count);
    end
  endgenerate

  assign too_long = CMP_W'(idx) >= CMP_W'(limit);

  // residency outranks the length test (R4 before R5)
  always_comb begin
    if (!resident)     desc_flt = FLT_SEG;
    else if (too_long) desc_flt = FLT_LEN;
    else               desc_flt = FLT_NONE;
  end

  assign pte_flt = present ? FLT_NONE : FLT_PAGE;

endmodule

// File: rtl/seg_xlate_ctrl.sv
module seg_xlate_ctrl
  import seg_xlate_pkg::*;
#(
  parameter int unsigned VA_W    = 32,
  parameter int unsigned OFF_W   = 12,
  parameter int unsigned PA_W    = 32,
  parameter int unsigned BASE_W  = 23,
  parameter int unsigned FRAME_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_va,
  output logic               done,
  output logic [1:0]         fault,
  output logic [PA_W-1:0]    paddr,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [PA_W-1:0]    mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [BASE_W-1:0]  rsp_base,
  input  logic [FRAME_W-1:0] rsp_frame,
  input  fault_e             desc_flt,
  input  fault_e             pte_flt,
  input  logic [PA_W-1:0]    desc_addr,
  input  logic [PA_W-1:0]    pte_addr,
  output logic [VA_W-1:0]    va_q,
  output logic [BASE_W-1:0]  base_q
);
  state_e          st;
  fault_e          flt_q;
  logic [PA_W-1:0] pa_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      va_q   <= '0;
      base_q <= '0;
      flt_q  <= FLT_NONE;
      pa_q   <= '0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          va_q <= req_va;
          st   <= ST_DREQ;
        end
        ST_DREQ: if (mem_req_ready) st <= ST_DWAIT;
        ST_DWAIT: if (mem_rsp_valid) begin
          base_q <= rsp_base;
          if (desc_flt != FLT_NONE) begin
            flt_q <= desc_flt;
            pa_q  <= '0;
            st    <= ST_DONE;
          end else begin
            st <= ST_PREQ;
          end
        end
        ST_PREQ: if (mem_req_ready) st <= ST_PWAIT;
        ST_PWAIT: if (mem_rsp_valid) begin
          if (pte_flt != FLT_NONE) begin
            flt_q <= FLT_PAGE;
            pa_q  <= '0;
          end else begin
            flt_q <= FLT_NONE;
            pa_q  <= PA_W'({rsp_frame, va_q[OFF_W-1:0]});
          end
          st <= ST_DONE;
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (st == ST_IDLE);
  assign done          = (st == ST_DONE);
  assign fault         = flt_q;
  assign paddr         = pa_q;
  assign mem_req_valid = (st == ST_DREQ) || (st == ST_PREQ);
  assign mem_req_addr  = (st == ST_PREQ) ? pte_addr : desc_addr;

  // read counter kept for the checks below
  logic [1:0] n_rd;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   n_rd <= '0;
    else if (req_valid && req_ready)              n_rd <= '0;
    else if (mem_req_valid && mem_req_ready && n_rd != 2'd3) n_rd <= n_rd + 2'd1;
  end

  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_hold_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_fault_pa_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault != 2'b00) |-> (paddr == '0));

  p_one_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault == 2'b01) |-> (n_rd == 2'd1));

  p_one_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault == 2'b11) |-> (n_rd == 2'd1));

  p_two_reads_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (fault == 2'b00 || fault == 2'b10)) |-> (n_rd == 2'd2));

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int unsigned     VA_W        = 32,
  parameter int unsigned     SEG_W       = 8,
  parameter int unsigned     OFF_W       = 12,
  parameter int unsigned     PA_W        = 32,
  parameter int unsigned     WORD_W      = 32,
  parameter int unsigned     LEN_W       = 8,
  parameter int unsigned     MAX_ENTRIES = 128,
  parameter int unsigned     ENTRY_BYTES = 4,
  parameter logic [PA_W-1:0] SEG_BASE    = 32'hF000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  output logic              done,
  output logic [1:0]        fault,
  output logic [PA_W-1:0]   paddr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data
);
  localparam int unsigned IDX_W      = VA_W - SEG_W - OFF_W;
  localparam int unsigned FRAME_W    = PA_W - OFF_W;
  localparam int unsigned BASE_W     = WORD_W - 1 - LEN_W;
  localparam int unsigned TBL_SHIFT  = $clog2(MAX_ENTRIES * ENTRY_BYTES);
  localparam int unsigned DESC_BYTES = WORD_W / 8;

  logic [VA_W-1:0]   va_q;
  logic [BASE_W-1:0] base_q;
  logic [PA_W-1:0]   desc_addr, pte_addr;
  fault_e            desc_flt, pte_flt;

  seg_xlate_addr #(
    .VA_W(VA_W), .SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W), .BASE_W(BASE_W),
    .ENTRY_BYTES(ENTRY_BYTES), .DESC_BYTES(DESC_BYTES), .TBL_SHIFT(TBL_SHIFT),
    .SEG_BASE(SEG_BASE)
  ) u_addr (
    .va_hi     (va_q[VA_W-1:OFF_W]),
    .tbl_base  (base_q),
    .desc_addr (desc_addr),
    .pte_addr  (pte_addr)
  );

  seg_xlate_classify #(
    .IDX_W(IDX_W), .LEN_W(LEN_W), .MAX_ENTRIES(MAX_ENTRIES)
  ) u_cls (
    .resident (mem_rsp_data[WORD_W-1]),
    .count    (mem_rsp_data[LEN_W-1:0]),
    .idx      (va_q[OFF_W +: IDX_W]),
    .present  (mem_rsp_data[WORD_W-1]),
    .desc_flt (desc_flt),
    .pte_flt  (pte_flt)
  );

  seg_xlate_ctrl #(
    .VA_W(VA_W), .OFF_W(OFF_W), .PA_W(PA_W), .BASE_W(BASE_W), .FRAME_W(FRAME_W)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_va        (req_va),
    .done          (done),
    .fault         (fault),
    .paddr         (paddr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .rsp_base      (mem_rsp_data[WORD_W-2 -: BASE_W]),
    .rsp_frame     (mem_rsp_data[FRAME_W-1:0]),
    .desc_flt      (desc_flt),
    .pte_flt       (pte_flt),
    .desc_addr     (desc_addr),
    .pte_addr      (pte_addr),
    .va_q          (va_q),
    .base_q        (base_q)
  );

endmodule

// File: tb/tb_seg_xlate.sv
module tb_seg_xlate;
  localparam logic [31:0] SEG_BASE = 32'hF000_0000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, req_valid, req_ready, done, mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [31:0] req_va, paddr, mem_req_addr, mem_rsp_data;
  logic [1:0]  fault;

  seg_xlate dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .done(done), .fault(fault), .paddr(paddr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  int compared = 0;
  int mismatched = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] desc_of(input int s);
    logic       res;
    logic [7:0] cnt;
    res = (s % 5) != 0;
    cnt = 8'((s * 7) % 141);
    return {res, 23'(s + 1), cnt};
  endfunction

  function automatic logic [31:0] pte_of(input logic [31:0] a);
    logic [31:0] w;
    w = a >> 2;
    return {((w % 3) != 0), 11'b0, 20'(w ^ 32'h5A5A5)};
  endfunction

  function automatic logic [31:0] mem_read(input logic [31:0] a);
    if (a >= SEG_BASE && a < SEG_BASE + 32'd1024) return desc_of(int'((a - SEG_BASE) >> 2));
    return pte_of(a);
  endfunction

  function automatic logic [31:0] mkva(input int s, input int i, input int o);
    return {8'(s), 12'(i), 12'(o)};
  endfunction

  // behavioural expectation from the requirements
  logic [1:0]  e_fault;
  logic [31:0] e_pa, e_ea, e_da;
  int          e_n;
  string       e_tag;

  task automatic predict(input logic [31:0] va);
    logic [31:0] d, p;
    int          lim, idx;
    d    = desc_of(int'(va[31:24]));
    idx  = int'(va[23:12]);
    lim  = (d[7:0] > 8'd128) ? 128 : int'(d[7:0]);
    e_da = SEG_BASE + {22'b0, va[31:24], 2'b00};
    e_ea = {d[30:8], 9'b0} + 32'(idx * 4);
    e_pa = '0;
    if (!d[31]) begin
      e_fault = 2'b01; e_n = 1; e_tag = "R4";
    end else if (idx >= lim) begin
      e_fault = 2'b11; e_n = 1; e_tag = "R5";
    end else begin
      e_n = 2;
      p = pte_of(e_ea);
      if (!p[31]) begin
        e_fault = 2'b10; e_tag = "R7";
      end else begin
        e_fault = 2'b00; e_tag = "R8"; e_pa = {p[19:0], va[11:0]};
      end
    end
  endtask

  logic [31:0] vq[$];

  initial begin
    bit          busy, prev_stall, prev_done;
    int          nrd, pend, cycles;
    logic [31:0] pend_data, prev_addr;

    rst_n = 1'b0; req_valid = 1'b0; req_va = '0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;

    // directed corner cases
    vq.push_back(mkva(1, 6, 'h123));    // last valid index, count 7
    vq.push_back(mkva(1, 7, 'h001));    // first index past the count
    vq.push_back(mkva(10, 100, 'h0));   // non-resident and too long together
    vq.push_back(mkva(0, 0, 'hfff));    // non-resident
    vq.push_back(mkva(19, 127, 'h456)); // count 133 clamps, 127 still valid
    vq.push_back(mkva(19, 128, 'h456)); // clamped limit rejects 128
    vq.push_back(mkva(141, 0, 'h10));   // count 0 rejects index 0
    vq.push_back(mkva(7, 4095, 'h0));   // widest index
    for (int k = 0; k < 40; k++) vq.push_back(mkva(2 + k % 3, k % 16, k * 37));
    for (int k = 0; k < 80; k++)
      vq.push_back(mkva(int'($urandom % 256), int'($urandom % 150), int'($urandom % 4096)));

    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R11", "req_ready in reset", 64'(req_ready), 64'd1);
    chk(done == 1'b0, "R11", "done in reset", 64'(done), 64'd0);
    chk(mem_req_valid == 1'b0, "R11", "mem_req_valid in reset", 64'(mem_req_valid), 64'd0);
    rst_n = 1'b1;

    busy = 0; prev_stall = 0; prev_done = 0; nrd = 0; pend = 0; cycles = 0;
    pend_data = '0; prev_addr = '0;

    forever begin
      @(negedge clk);
      cycles++;

      chk(req_ready == !busy, "R1", "req_ready", 64'(req_ready), 64'(!busy));
      if (prev_stall)
        chk(mem_req_valid && mem_req_addr == prev_addr, "R10", "held request",
            {31'b0, mem_req_valid, mem_req_addr}, {32'd1, prev_addr});
      if (mem_req_valid) begin
        if (!busy || nrd >= e_n)
          chk(1'b0, busy ? e_tag : "R10", "unexpected read", 64'(mem_req_addr), 64'd0);
        else if (nrd == 0)
          chk(mem_req_addr == e_da, "R2", "descriptor address", 64'(mem_req_addr), 64'(e_da));
        else
          chk(mem_req_addr == e_ea, "R3 R6", "entry address", 64'(mem_req_addr), 64'(e_ea));
      end
      if (prev_done) chk(!done, "R9", "done width", 64'(done), 64'd0);
      if (done) begin
        if (!busy) chk(1'b0, "R9", "done while idle", 64'd1, 64'd0);
        else begin
          chk(fault == e_fault, e_tag, "fault", 64'(fault), 64'(e_fault));
          chk(paddr == e_pa, (e_fault == 2'b00) ? "R8" : "R9", "paddr", 64'(paddr), 64'(e_pa));
          chk(nrd == e_n, e_tag, "read count", 64'(nrd), 64'(e_n));
          busy = 0;
        end
      end
      prev_done = done;

      // memory side
      mem_rsp_valid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = pend_data;
        end
      end
      mem_req_ready = ($urandom % 4) != 0;
      prev_stall = mem_req_valid && !mem_req_ready;
      prev_addr  = mem_req_addr;
      if (mem_req_valid && mem_req_ready) begin
        pend = 1 + int'($urandom % 3);
        pend_data = mem_read(mem_req_addr);
        nrd++;
      end

      // request side: valid is often held through a busy period
      if (vq.size() > 0 && (req_valid || busy || ($urandom % 3) != 0)) begin
        req_valid = 1'b1;
        req_va    = vq[0];
      end else begin
        req_valid = 1'b0;
      end
      if (req_valid && req_ready) begin
        predict(vq[0]);
        void'(vq.pop_front());
        busy = 1;
        nrd  = 0;
        req_valid = 1'b1;
      end

      if (vq.size() == 0 && !busy) break;
      if (cycles > 150000) begin
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        break;
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule